// File: doc/BRIEF.md
# Condition Flag and Predicate Unit

This block keeps the four arithmetic status flags of a processor datapath (negative, zero, carry, overflow) and decides, every cycle, whether the instruction now in execute may take effect. It computes a W-bit add, subtract, compare or move-through-shifter result from two operands. It updates the flags from that result when the instruction asks for it. It also tests a 4-bit condition field against the flags held before the current instruction.

The single `cond_pass` bit gates a conditional branch or any predicated instruction. When the condition fails, nothing changes: the flags keep their value and `res_we` stays low, so the register file is not written. A compare always updates the flags but never asks for a register write. Any other operation updates the flags only when `set_flags` is high.

Top module: `flag_pred_unit`

## Requirements
- R1: On a flag update, N (bit 3 of `flags`) takes bit W-1 of the result.
- R2: On a flag update, Z (bit 2 of `flags`) is 1 exactly when every result bit is 0.
- R3: On a flag update, C (bit 1 of `flags`) is set as follows. For add (op 00) it is the carry out of the top bit. For subtract (op 01) and compare (op 10) it is 1 when no borrow occurs, that is when op_a >= op_b unsigned. For move (op 11) it takes `shift_carry`.
- R4: On a flag update, V (bit 0 of `flags`) is set as follows. For add, subtract and compare it is 1 when the two's-complement result overflows. For move, V keeps its previous value.
- R5: Compare (op 10) computes op_a - op_b on `result` and updates all four flags even when `set_flags` is 0, and it holds `res_we` at 0.
- R6: Add, subtract and move update the flags only when `set_flags` is 1, and raise `res_we` whenever the condition passes. The move result equals op_b.
- R7: `cond_pass` follows the condition code against the stored flags. The codes are: 0000 Z; 0001 !Z; 0010 C; 0011 !C; 0100 N; 0101 !N; 0110 V; 0111 !V; 1000 C&!Z; 1001 !C|Z; 1010 N==V; 1011 N!=V; 1100 !Z&(N==V); 1101 Z|(N!=V).
- R8: Code 1110 always passes and code 1111 never passes.
- R9: When `cond_pass` is 0, the flags do not change at the next edge and `res_we` is 0.
- R10: The condition is tested against the flags registered before the current operation. A flag update becomes visible to the condition test in the following cycle.
- R11: Driving `rst_n` low clears the flags at once. After `rst_n` rises, the flags stay clear for the following two clock edges, and release is synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand or shifter output |
| op_sel | input | 2 | 00 add, 01 subtract, 10 compare, 11 move |
| set_flags | input | 1 | Request a flag update |
| shift_carry | input | 1 | Carry out of the shifter, used by move |
| cond | input | 4 | Condition code |
| result | output | W | Operation result |
| flags | output | 4 | {N, Z, C, V} |
| res_we | output | 1 | Result may be written to the destination |
| cond_pass | output | 1 | Condition satisfied: execute or take branch |

## Verification
The bench builds the unit with W=32 and two reset-release stages. At that width the corner operands are meaningful: 0x7FFFFFFF+1, 0-1, 0x80000000-1, 0xFFFFFFFF+1 and equal operands. These exercise the carry, borrow and signed-overflow edges. Expected flags come from 33-bit unsigned and sign-extended arithmetic rather than the bit formulas the unit uses. A sweep runs all sixteen condition codes over several flag states, and a random run mixes operations, set-flag requests and conditions so that failed predicates land between flag updates.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_CMP = 2'b10,
    OP_MOV = 2'b11
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam int CONDW = 4;
  localparam logic [CONDW-1:0] CC_ALWAYS = 4'b1110;
  localparam logic [CONDW-1:0] CC_NEVER  = 4'b1111;
endpackage

// File: rtl/flagu_rst_sync.sv
module flagu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_ok = sh_q[STAGES-1];
endmodule

// File: rtl/flagu_arith.sv
module flagu_arith
  import flagu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_e          op,
  input  logic         shc,
  input  flags_t       cur,
  output logic [W-1:0] res,
  output flags_t       nxt
);
  localparam int MSB = W - 1;

  logic         is_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  // One adder serves add, subtract and compare: subtract is a + ~b + 1.
  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_CMP);
    b_eff  = is_sub ? ~b : b;
    sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  end

  always_comb begin
    nxt = cur;
    if (op == OP_MOV) begin
      res   = b;
      nxt.c = shc;
    end else begin
      res   = sum[W-1:0];
      nxt.c = sum[W];
      if (is_sub) nxt.v = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
      else        nxt.v = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
    end
    nxt.n = res[MSB];
    nxt.z = (res == '0);
  end
endmodule

// File: rtl/flagu_cond.sv
module flagu_cond
  import flagu_pkg::*;
(
  input  logic [CONDW-1:0] cond,
  input  flags_t           fl,
  output logic             pass
);
  logic base;

  // Even codes give the base test; odd codes invert it (1111 inverts always).
  always_comb begin
    unique case (cond[3:1])
      3'd0: base = fl.z;
      3'd1: base = fl.c;
      3'd2: base = fl.n;
      3'd3: base = fl.v;
      3'd4: base = fl.c && !fl.z;
      3'd5: base = (fl.n == fl.v);
      3'd6: base = !fl.z && (fl.n == fl.v);
      default: base = 1'b1;
    endcase
    pass = base ^ cond[0];
  end
endmodule

// File: rtl/flag_pred_unit.sv
module flag_pred_unit
  import flagu_pkg::*;
#(
  parameter int W          = 32,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op_sel,
  input  logic         set_flags,
  input  logic         shift_carry,
  input  logic [3:0]   cond,
  output logic [W-1:0] result,
  output logic [3:0]   flags,
  output logic         res_we,
  output logic         cond_pass
);
  logic   rst_ok;
  op_e    op;
  flags_t flg_q, flg_d, alu_nxt;
  logic   flag_we;

  assign op = op_e'(op_sel);

  flagu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  flagu_arith #(.W(W)) u_arith (
    .a(op_a), .b(op_b), .op(op), .shc(shift_carry),
    .cur(flg_q), .res(result), .nxt(alu_nxt)
  );

  flagu_cond u_cond (
    .cond(cond), .fl(flg_q), .pass(cond_pass)
  );

  always_comb begin
    flag_we = cond_pass && (set_flags || (op == OP_CMP));
    res_we  = cond_pass && (op != OP_CMP);
    flg_d   = alu_nxt;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      flg_q <= '0;
    else if (flag_we) flg_q <= flg_d;
  end

  assign flags = flg_q;

  // R9
  hold_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !cond_pass |=> $stable(flags));
  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_sel == 2'b10) |-> !res_we);
  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    flag_we |=> (flags[2] == ($past(result) == '0)));
  // R1
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    flag_we |=> (flags[3] == $past(result[W-1])));
endmodule

// File: tb/sim_flag_pred_unit.sv
module sim_flag_pred_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] op_a, op_b, result;
  logic [1:0]   op_sel;
  logic         set_flags, shift_carry, res_we, cond_pass;
  logic [3:0]   cond, flags;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic         pass;
    logic         we;
    logic [W-1:0] res;
    logic [3:0]   fl;
    string        tag;
  } item_t;

  item_t q[$];
  logic [3:0] mfl;

  always #5 clk = ~clk;

  flag_pred_unit #(.W(W), .RST_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .set_flags(set_flags), .shift_carry(shift_carry), .cond(cond),
    .result(result), .flags(flags), .res_we(res_we), .cond_pass(cond_pass)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Condition codes from the requirement table, flags {N,Z,C,V}
  function automatic logic ref_cond(logic [3:0] c, logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b,
                       logic sf, logic [3:0] c, logic shc, string tag);
    item_t it;
    logic [W:0]          u;
    logic signed [W+1:0] s;
    logic [3:0]          nf;
    logic                wr;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; set_flags = sf; cond = c; shift_carry = shc;
    it.pass = ref_cond(c, mfl);
    nf = mfl;
    if (op == 2'b11) begin
      it.res = b;
      nf[1]  = shc;
    end else if (op == 2'b00) begin
      u = {1'b0, a} + {1'b0, b};
      s = $signed({{2{a[W-1]}}, a}) + $signed({{2{b[W-1]}}, b});
      it.res = u[W-1:0];
      nf[1]  = u[W];
      nf[0]  = (s > 64'sh7FFFFFFF) || (s < -64'sh80000000);
    end else begin
      s = $signed({{2{a[W-1]}}, a}) - $signed({{2{b[W-1]}}, b});
      it.res = a - b;
      nf[1]  = (a >= b);
      nf[0]  = (s > 64'sh7FFFFFFF) || (s < -64'sh80000000);
    end
    nf[3] = it.res[W-1];
    nf[2] = (it.res == 0);
    wr    = it.pass && (sf || op == 2'b10);
    it.we = it.pass && (op != 2'b10);
    if (wr) mfl = nf;
    it.fl  = mfl;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: combinational outputs before the edge, flags after it
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        it = q.pop_front();
        check({it.tag, " cond_pass"}, 64'(cond_pass), 64'(it.pass));
        check({it.tag, " res_we"},    64'(res_we),    64'(it.we));
        check({it.tag, " result"},    64'(result),    64'(it.res));
        @(posedge clk);
        #1;
        check({it.tag, " flags"},     64'(flags),     64'(it.fl));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; op_sel = 2'b00;
    set_flags = 1'b0; shift_carry = 1'b0; cond = 4'hE;
    mfl = 4'h0;
    #2;
    check("R11 flags in reset", 64'(flags), 64'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R11 flags one edge after release", 64'(flags), 64'h0);
    repeat (3) @(negedge clk);

    // R1 R4: signed overflow on add
    drive(2'b00, 32'h7FFFFFFF, 32'h1, 1, 4'hE, 0, "R1 R4 add 7fffffff+1");
    drive(2'b11, 32'h5, 32'h9, 0, 4'h6, 0, "R7 VS after overflow");
    // R3: borrow on 0-1
    drive(2'b01, 32'h0, 32'h1, 1, 4'hE, 0, "R3 sub 0-1");
    // R5 R4: compare with overflow, no set_flags
    drive(2'b10, 32'h80000000, 32'h1, 0, 4'hE, 0, "R5 R4 cmp 80000000-1");
    // R2 R5: equal operands
    drive(2'b10, 32'h1234, 32'h1234, 0, 4'hE, 0, "R2 R5 cmp equal");
    // R10: EQ tests old Z=1 while this compare clears it
    drive(2'b10, 32'h1, 32'h2, 0, 4'h0, 0, "R10 EQ uses prior flags");
    drive(2'b11, 32'h0, 32'h7, 0, 4'h0, 0, "R10 EQ sees new flags");
    // R3 R2: carry out to zero
    drive(2'b00, 32'hFFFFFFFF, 32'h1, 1, 4'hE, 0, "R3 R2 add wraps to zero");
    // R6: no set_flags on add leaves flags
    drive(2'b00, 32'h80000000, 32'h80000000, 0, 4'hE, 0, "R6 add without set_flags");
    // R9: NE fails with Z=1, compare must not touch flags
    drive(2'b10, 32'h0, 32'h1, 1, 4'h1, 0, "R9 failed compare");
    drive(2'b00, 32'h3, 32'h4, 1, 4'h1, 0, "R9 failed add");
    // R8
    drive(2'b00, 32'h3, 32'h4, 1, 4'hF, 0, "R8 never code");
    drive(2'b01, 32'h9, 32'h4, 1, 4'hE, 0, "R8 always code");
    // R3 R4 R6: move takes shifter carry, keeps V
    drive(2'b00, 32'h7FFFFFFF, 32'h7FFFFFFF, 1, 4'hE, 0, "R4 set V");
    drive(2'b11, 32'h0, 32'h80000000, 1, 4'hE, 1, "R3 R4 R6 move shifter carry");

    // R7: every code over several flag states
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: drive(2'b10, 32'h5, 32'h5, 0, 4'hE, 0, "R7 setup eq");
        1: drive(2'b10, 32'h1, 32'h5, 0, 4'hE, 0, "R7 setup lo");
        2: drive(2'b10, 32'h9, 32'h5, 0, 4'hE, 0, "R7 setup hi");
        3: drive(2'b10, 32'h80000000, 32'h1, 0, 4'hE, 0, "R7 setup ovf");
        4: drive(2'b10, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 4'hE, 0, "R7 setup ovf neg");
        default: drive(2'b10, 32'hFFFFFFF0, 32'h10, 0, 4'hE, 0, "R7 setup neg");
      endcase
      for (int c = 0; c < 16; c++)
        drive(2'b11, 32'h0, 32'(c), 0, 4'(c), 0, "R7 code sweep");
    end

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = (i % 7 == 0) ? ra : W'($urandom);
      drive(2'($urandom), ra, rb, 1'($urandom), 4'($urandom), 1'($urandom),
            "R1 R2 R3 R4 R6 R7 R9 random");
    end

    @(negedge clk);
    cond = 4'hF;
    repeat (3) @(negedge clk);

    // R11: asynchronous clear mid-cycle
    drive(2'b00, 32'h80000000, 32'h80000000, 1, 4'hE, 0, "R11 setup flags");
    @(negedge clk);
    cond = 4'hF;
    repeat (2) @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R11 async clear", 64'(flags), 64'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule